// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block is the processor-side controller that turns a pending prioritized interrupt request into a vector address. It accepts two request sources, an internal periodic-timer source and an external source, each with a 3-bit level. When a request is pending and the core signals an instruction boundary, the sequencer picks a source and raises a one-cycle stacking strobe, which also clears the program-bank extension field of the condition-code register. It then runs a CPU-space acknowledge bus cycle that carries the acknowledged level on the address lines.

The acknowledge cycle ends in one of three ways. A responder can return a vector number with normal termination. A responder can request an autovector, which is derived from the level. A bus-monitor timeout can fire, either from the internal cycle counter or from an external monitor, and this selects the spurious vector. The sequencer then reports the vector number and the vector address for one cycle and returns to idle. The level is copied from the address lines into an interrupt-priority register that stays visible on a port.

Top module: `irq_ack_seq`

## Requirements
- R1: Acknowledge processing starts only in a cycle where a request (timer or external) is pending and the instruction-boundary input is high. The stacking strobe then appears in the next cycle. Without both conditions, no strobe and no bus cycle occur.
- R2: `stack_o` and `pk_clr_o` are high together for exactly one cycle. The acknowledge bus cycle (`ack_cyc_o` high) starts in the cycle right after.
- R3: While `ack_cyc_o` is high, `fc_o` is 3'b111 and `addr_o` has bits 23..4 set, bits 3..1 equal to the acknowledged level, and bit 0 set. Outside the cycle, `fc_o` and `addr_o` are zero.
- R4: `ipl_o` loads `addr_o[3:1]` at the end of the first acknowledge cycle. At all other times it holds its value, and reset clears it to 0.
- R5: When `dtack_i` ends the cycle with `avec_i` low, the vector number is `data_i` as sampled in that cycle.
- R6: When `avec_i` ends the cycle, the vector number is AVEC_BASE (default 8'h30) plus the level. `avec_i` wins over `dtack_i` when both are high in the same cycle.
- R7: A timeout selects the spurious vector SPUR_VEC (default 8'h0F). A timeout is either `bmon_tmo_i` high, or TMO_CYC acknowledge cycles (default 16) passing with no termination. The acknowledge cycle then lasts at most TMO_CYC cycles. A `dtack_i` or `avec_i` in the same cycle as a timeout wins over it.
- R8: The source with the higher level wins. On equal levels the timer source wins. `tmr_sel_o` is 1 when the timer source was picked and 0 when the external source was picked.
- R9: `done_o` is high for exactly one cycle, in the cycle after termination. `vec_addr_o` is the vector number shifted left by one and zero-extended. The sequencer is then idle and can accept a new request.
- R10: After reset, all strobes are low, the bus lines are zero, and `ipl_o`, `vec_num_o` and `vec_addr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tmr_req_i | input | 1 | Periodic-timer request pending |
| tmr_lvl_i | input | 3 | Timer request level |
| ext_req_i | input | 1 | External request pending |
| ext_lvl_i | input | 3 | External request level |
| insn_bnd_i | input | 1 | Core at instruction boundary |
| dtack_i | input | 1 | Normal termination with supplied vector |
| avec_i | input | 1 | Autovector termination |
| bmon_tmo_i | input | 1 | External bus-monitor timeout |
| data_i | input | 8 | Vector number from responder |
| fc_o | output | 3 | Function-code lines |
| addr_o | output | 24 | Address lines |
| ack_cyc_o | output | 1 | Acknowledge bus cycle active |
| stack_o | output | 1 | Stack processor state strobe |
| pk_clr_o | output | 1 | Clear program-bank extension field |
| ipl_o | output | 3 | Latched interrupt-priority field |
| tmr_sel_o | output | 1 | Timer source was selected |
| vec_num_o | output | 8 | Resulting vector number |
| vec_addr_o | output | 24 | Resulting vector address |
| done_o | output | 1 | Vector result valid (one cycle) |

## Verification
Timing is counted from a negative edge where a request and a boundary are driven. The stacking strobe is due one cycle later, and the bus drive one cycle after that. `done_o`, the vector number and the new `ipl_o` are due one cycle after the terminating input is driven. With no response, `done_o` is due exactly TMO_CYC cycles after the first acknowledge cycle. Every task drives inputs on a negative edge and samples one edge later at exactly these cycles. The checks also confirm that the bus is still active in the last acknowledge cycle before a timeout.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_STACK = 2'd1,
      ST_ACK   = 2'd2,
      ST_DONE  = 2'd3
   } seq_st_e;

   typedef enum logic [1:0] {
      TK_NONE     = 2'd0,
      TK_SUPPLIED = 2'd1,
      TK_AUTO     = 2'd2,
      TK_SPUR     = 2'd3
   } term_kind_e;
endpackage

// File: rtl/irq_src_arb.sv
module irq_src_arb #(
   parameter int LVL_W = 3
) (
   input  logic             tmr_req_i,
   input  logic [LVL_W-1:0] tmr_lvl_i,
   input  logic             ext_req_i,
   input  logic [LVL_W-1:0] ext_lvl_i,
   output logic             any_o,
   output logic             pick_tmr_o,
   output logic [LVL_W-1:0] lvl_o
);
   if (LVL_W < 1) begin : g_bad_lvl
      $error("irq_src_arb: LVL_W must be at least 1");
   end

   always_comb begin
      any_o      = tmr_req_i | ext_req_i;
      // equal levels resolve toward the internal timer source
      pick_tmr_o = tmr_req_i & (~ext_req_i | (tmr_lvl_i >= ext_lvl_i));
      lvl_o      = pick_tmr_o ? tmr_lvl_i : ext_lvl_i;
   end
endmodule

// File: rtl/irq_ack_tmo.sv
module irq_ack_tmo #(
   parameter int TMO_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expire_o
);
   localparam int CNT_W = $clog2(TMO_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("irq_ack_tmo: TMO_CYC must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign expire_o = run_i & (cnt_q == LAST);

   AST_TMO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R7
   AST_TMO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> cnt_q == '0); // R7
endmodule

// File: rtl/irq_ack_bus.sv
module irq_ack_bus #(
   parameter int ADDR_W = 24,
   parameter int FC_W   = 3,
   parameter int LVL_W  = 3
) (
   input  logic              active_i,
   input  logic [LVL_W-1:0]  lvl_i,
   output logic [FC_W-1:0]   fc_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int LVL_HI = LVL_W;

   if (ADDR_W < LVL_W + 2) begin : g_bad_addr
      $error("irq_ack_bus: ADDR_W too narrow for level field");
   end

   always_comb begin
      fc_o   = '0;
      addr_o = '0;
      if (active_i) begin
         fc_o               = '1;
         addr_o             = '1;
         addr_o[LVL_HI:1]   = lvl_i;
      end
   end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
   import irq_ack_pkg::*;
#(
   parameter int VEC_W     = 8,
   parameter int LVL_W     = 3,
   parameter int ADDR_W    = 24,
   parameter int AVEC_BASE = 'h30,
   parameter int SPUR_VEC  = 'h0F,
   parameter int VEC_SHIFT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  term_kind_e        kind_i,
   input  logic [VEC_W-1:0]  data_i,
   input  logic [LVL_W-1:0]  lvl_i,
   output logic [VEC_W-1:0]  vec_num_o,
   output logic [ADDR_W-1:0] vec_addr_o
);
   localparam logic [VEC_W-1:0] AVEC_V = VEC_W'(AVEC_BASE);
   localparam logic [VEC_W-1:0] SPUR_V = VEC_W'(SPUR_VEC);

   if (VEC_W + VEC_SHIFT > ADDR_W) begin : g_bad_vw
      $error("irq_vec_gen: vector address exceeds ADDR_W");
   end
   if (AVEC_BASE + (1 << LVL_W) - 1 >= (1 << VEC_W)) begin : g_bad_base
      $error("irq_vec_gen: autovector range overflows VEC_W");
   end

   logic [VEC_W-1:0] vec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_q <= '0;
      else if (load_i) begin
         case (kind_i)
            TK_SUPPLIED: vec_q <= data_i;
            TK_AUTO:     vec_q <= AVEC_V + VEC_W'(lvl_i);
            default:     vec_q <= SPUR_V;
         endcase
      end
   end

   assign vec_num_o = vec_q;

   if (VEC_SHIFT == 0) begin : g_noshift
      assign vec_addr_o = ADDR_W'(vec_q);
   end else begin : g_shift
      assign vec_addr_o = ADDR_W'({vec_q, {VEC_SHIFT{1'b0}}});
   end

   AST_AVEC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && kind_i == TK_AUTO) |=> vec_num_o == AVEC_V + VEC_W'($past(lvl_i))); // R6
   AST_SPUR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && kind_i == TK_SPUR) |=> vec_num_o == SPUR_V); // R7
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
   import irq_ack_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int FC_W      = 3,
   parameter int LVL_W     = 3,
   parameter int VEC_W     = 8,
   parameter int TMO_CYC   = 16,
   parameter int AVEC_BASE = 'h30,
   parameter int SPUR_VEC  = 'h0F,
   parameter int VEC_SHIFT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tmr_req_i,
   input  logic [LVL_W-1:0]  tmr_lvl_i,
   input  logic              ext_req_i,
   input  logic [LVL_W-1:0]  ext_lvl_i,
   input  logic              insn_bnd_i,
   input  logic              dtack_i,
   input  logic              avec_i,
   input  logic              bmon_tmo_i,
   input  logic [VEC_W-1:0]  data_i,
   output logic [FC_W-1:0]   fc_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              ack_cyc_o,
   output logic              stack_o,
   output logic              pk_clr_o,
   output logic [LVL_W-1:0]  ipl_o,
   output logic              tmr_sel_o,
   output logic [VEC_W-1:0]  vec_num_o,
   output logic [ADDR_W-1:0] vec_addr_o,
   output logic              done_o
);
   seq_st_e          st_q, st_d;
   logic [LVL_W-1:0] lvl_q, ipl_q, arb_lvl;
   logic             tmr_sel_q, arb_any, arb_tmr;
   logic             ack_first_q, tmo_hit;
   term_kind_e       kind;

   irq_src_arb #(.LVL_W(LVL_W)) u_arb (
      .tmr_req_i (tmr_req_i),
      .tmr_lvl_i (tmr_lvl_i),
      .ext_req_i (ext_req_i),
      .ext_lvl_i (ext_lvl_i),
      .any_o     (arb_any),
      .pick_tmr_o(arb_tmr),
      .lvl_o     (arb_lvl)
   );

   irq_ack_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (st_q == ST_ACK),
      .expire_o(tmo_hit)
   );

   irq_ack_bus #(.ADDR_W(ADDR_W), .FC_W(FC_W), .LVL_W(LVL_W)) u_bus (
      .active_i(st_q == ST_ACK),
      .lvl_i   (lvl_q),
      .fc_o    (fc_o),
      .addr_o  (addr_o)
   );

   // termination precedence: autovector, supplied vector, timeout
   always_comb begin
      kind = TK_NONE;
      if (st_q == ST_ACK) begin
         if (avec_i)                       kind = TK_AUTO;
         else if (dtack_i)                 kind = TK_SUPPLIED;
         else if (tmo_hit || bmon_tmo_i)   kind = TK_SPUR;
      end
   end

   irq_vec_gen #(
      .VEC_W(VEC_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W),
      .AVEC_BASE(AVEC_BASE), .SPUR_VEC(SPUR_VEC), .VEC_SHIFT(VEC_SHIFT)
   ) u_vec (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (kind != TK_NONE),
      .kind_i    (kind),
      .data_i    (data_i),
      .lvl_i     (lvl_q),
      .vec_num_o (vec_num_o),
      .vec_addr_o(vec_addr_o)
   );

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (arb_any && insn_bnd_i) st_d = ST_STACK;
         ST_STACK: st_d = ST_ACK;
         ST_ACK:   if (kind != TK_NONE) st_d = ST_DONE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         lvl_q       <= '0;
         tmr_sel_q   <= 1'b0;
         ipl_q       <= '0;
         ack_first_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && st_d == ST_STACK) begin
            lvl_q     <= arb_lvl;
            tmr_sel_q <= arb_tmr;
         end
         if (st_q == ST_STACK) ack_first_q <= 1'b1;
         else if (st_q == ST_ACK) ack_first_q <= 1'b0;
         // priority field is taken from the driven address lines
         if (st_q == ST_ACK && ack_first_q) ipl_q <= addr_o[LVL_W:1];
      end
   end

   assign ack_cyc_o = (st_q == ST_ACK);
   assign stack_o   = (st_q == ST_STACK);
   assign pk_clr_o  = (st_q == ST_STACK);
   assign done_o    = (st_q == ST_DONE);
   assign ipl_o     = ipl_q;
   assign tmr_sel_o = tmr_sel_q;

   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stack_o) |-> $past(insn_bnd_i) && $past(tmr_req_i || ext_req_i)); // R1
   AST_STACK_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      stack_o |=> (ack_cyc_o && !stack_o && !pk_clr_o)); // R2
   AST_CPU_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_cyc_o |-> (fc_o == '1 && addr_o[0] && (&addr_o[ADDR_W-1:LVL_W+1]))); // R3
   AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_cyc_o |-> (fc_o == '0 && addr_o == '0)); // R3
   AST_IPL_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_cyc_o) |=> ipl_o == $past(addr_o[LVL_W:1])); // R4
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !ack_cyc_o)); // R9
   AST_VADDR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> vec_addr_o == ADDR_W'({vec_num_o, {VEC_SHIFT{1'b0}}})); // R9
endmodule

// File: tb/irq_ack_seq_tb.sv
module irq_ack_seq_tb;
   localparam int TMO  = 16;
   localparam int AVB  = 'h30;
   localparam int SPUR = 'h0F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tmr_req, ext_req, bnd, dtack, avec, bmon;
   logic [2:0]  tmr_lvl, ext_lvl;
   logic [7:0]  data;
   logic [2:0]  fc, ipl;
   logic [23:0] addr, vaddr;
   logic        ack_cyc, stk, pkc, tsel, done;
   logic [7:0]  vnum;
   int          n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   irq_ack_seq #(.TMO_CYC(TMO), .AVEC_BASE(AVB), .SPUR_VEC(SPUR)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .tmr_req_i(tmr_req), .tmr_lvl_i(tmr_lvl),
      .ext_req_i(ext_req), .ext_lvl_i(ext_lvl),
      .insn_bnd_i(bnd), .dtack_i(dtack), .avec_i(avec), .bmon_tmo_i(bmon),
      .data_i(data), .fc_o(fc), .addr_o(addr), .ack_cyc_o(ack_cyc),
      .stack_o(stk), .pk_clr_o(pkc), .ipl_o(ipl), .tmr_sel_o(tsel),
      .vec_num_o(vnum), .vec_addr_o(vaddr), .done_o(done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] ack_addr(input logic [2:0] l);
      return {20'hFFFFF, l, 1'b1};
   endfunction

   task automatic idle_inputs();
      tmr_req = 0; ext_req = 0; tmr_lvl = 0; ext_lvl = 0;
      bnd = 0; dtack = 0; avec = 0; bmon = 0; data = 0;
   endtask

   // request + boundary at a negedge; returns at the first acknowledge negedge
   task automatic launch(input logic tr, input logic [2:0] tl, input logic er, input logic [2:0] el);
      @(negedge clk);
      tmr_req = tr; tmr_lvl = tl; ext_req = er; ext_lvl = el; bnd = 1;
      @(negedge clk);
      idle_inputs();
      chk("R1 stack strobe after request+boundary", stk, 1);
      chk("R2 bank clear with stack", pkc, 1);
      chk("R2 no bus during stack", ack_cyc, 0);
      @(negedge clk);
      chk("R2 stack is one cycle", stk, 0);
      chk("R2 bus cycle follows stack", ack_cyc, 1);
   endtask

   task automatic t_reset();
      chk("R10 reset stack", stk, 0);
      chk("R10 reset ack", ack_cyc, 0);
      chk("R10 reset done", done, 0);
      chk("R10 reset fc", fc, 0);
      chk("R10 reset addr", addr, 0);
      chk("R10 reset ipl", ipl, 0);
      chk("R10 reset vec", vnum, 0);
      chk("R10 reset vaddr", vaddr, 0);
   endtask

   task automatic t_no_start();
      @(negedge clk); ext_req = 1; ext_lvl = 6;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R1 no start without boundary", {stk, ack_cyc}, 0);
      end
      ext_req = 0; bnd = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R1 no start without request", {stk, ack_cyc}, 0);
      end
      idle_inputs();
   endtask

   task automatic t_supplied();
      launch(0, 0, 1, 5);
      chk("R3 fc cpu space", fc, 3'b111);
      chk("R3 ack address lvl5", addr, ack_addr(5));
      chk("R8 external picked", tsel, 0);
      dtack = 1; data = 8'h42;
      @(negedge clk); idle_inputs();
      chk("R5 supplied vector", vnum, 8'h42);
      chk("R9 done pulse", done, 1);
      chk("R9 vector address", vaddr, 24'h84);
      chk("R4 ipl latched", ipl, 5);
      chk("R3 bus released", {fc, addr}, 0);
      @(negedge clk);
      chk("R9 done one cycle", done, 0);
      chk("R4 ipl holds", ipl, 5);
   endtask

   task automatic t_auto();
      launch(1, 3, 0, 0);
      chk("R3 ack address lvl3", addr, ack_addr(3));
      chk("R8 timer alone picked", tsel, 1);
      @(negedge clk); @(negedge clk);
      chk("R3 bus held while waiting", ack_cyc, 1);
      chk("R4 ipl set after first cycle", ipl, 3);
      avec = 1; dtack = 1; data = 8'h99;
      @(negedge clk); idle_inputs();
      chk("R6 autovector beats dtack", vnum, 8'h33);
      chk("R9 autovector address", vaddr, 24'h66);
      chk("R9 done after autovector", done, 1);
   endtask

   task automatic t_tie();
      launch(1, 4, 1, 4);
      chk("R8 tie goes to timer", tsel, 1);
      chk("R3 tie address", addr, ack_addr(4));
      dtack = 1; data = 8'h10;
      @(negedge clk); idle_inputs();
      chk("R5 tie vector", vnum, 8'h10);
      launch(1, 3, 1, 6);
      chk("R8 higher external wins", tsel, 0);
      chk("R3 address lvl6", addr, ack_addr(6));
      dtack = 1; data = 8'hA5;
      @(negedge clk); idle_inputs();
      chk("R5 vector A5", vnum, 8'hA5);
      chk("R4 ipl 6", ipl, 6);
   endtask

   task automatic t_timeout(input logic answer_late);
      launch(0, 0, 1, 2);
      for (int i = 1; i < TMO; i++) @(negedge clk);
      chk("R7 bus active in last cycle", ack_cyc, 1);
      chk("R7 no done before timeout", done, 0);
      if (answer_late) begin dtack = 1; data = 8'h55; end
      @(negedge clk); idle_inputs();
      chk("R7 done at timeout", done, 1);
      if (answer_late) chk("R7 termination beats timeout", vnum, 8'h55);
      else begin
         chk("R7 spurious vector", vnum, SPUR);
         chk("R9 spurious address", vaddr, 24'h1E);
      end
   endtask

   task automatic t_bmon();
      launch(1, 1, 0, 0);
      bmon = 1;
      @(negedge clk); idle_inputs();
      chk("R7 external monitor spurious", vnum, SPUR);
      chk("R7 done on monitor", done, 1);
      chk("R4 ipl 1", ipl, 1);
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_no_start();
      t_supplied();
      t_auto();
      t_tie();
      t_timeout(0);
      t_timeout(1);
      t_bmon();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule